// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-signal serial link. The signals are an active-high chip enable, a serial clock and one bidirectional data line. Through this link an external host reads and writes a 32-entry byte register space. The register space itself sits outside the block. The block reaches it through a plain register-file port: an address, write data, a one-cycle write strobe and combinational read data. It also drives the data pin through an output value and a separate output enable, so the pad can be tristated.

Each transfer starts when chip enable rises and ends when it falls. The first byte is a command that carries a register address and a direction flag. A single-byte transfer touches one register. The reserved address 31 starts a burst over registers 0 to 15 in ascending order. Every byte travels least significant bit first. Write data is sampled on rising serial clock edges. Read data is launched on falling edges.

The serial clock, the data input and chip enable all pass through two-flop synchronizers into the system clock domain. Edges are found there. The serial clock must therefore be several times slower than the system clock.

Top module: `serial3w_regport`

## Requirements
- R1: Dropping chip enable in the middle of a byte discards the partial command or data. No strobe is issued, and the next transfer decodes a fresh command.
- R2: Command and data bytes are shifted least significant bit first, one bit per serial clock.
- R3: The data output enable (`sdio_oe`) is low while `ce_i` is low. It is also low during the command byte and during write transfers.
- R4: The command layout is fixed. Bit 7 must be 1 and bit 6 must be 0. Bits 5..1 are the register address. Bit 0 selects read (1) or write (0). A command with bit 7 = 0 or bit 6 = 1 causes no write strobe and no drive of the data line.
- R5: In a single write, the data byte is taken from the 8 rising edges that follow the command. It is written with exactly one strobe of one system clock, to the commanded address. Further serial clocks in that transfer are ignored.
- R6: In a read, bit 0 of the addressed register is driven from the first falling edge after the last command bit. Each later falling edge presents the next bit.
- R7: In a single read, extra serial clocks resend the same register byte for as long as chip enable stays high.
- R8: A burst write (command 0xBE) writes successive bytes to addresses 0 through 15 in order, with one strobe each. Bytes after the sixteenth are ignored.
- R9: A burst read (command 0xBF) returns registers 0 through 15 in order. After the sixteenth byte, the data line is released.
- R10: While `wp_i` is high, every write strobe is suppressed except one addressed to the protect register (default address 7).
- R11: After reset, `sdio_oe` and `reg_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Serial chip enable, active high |
| sclk_i | input | 1 | Serial clock from host |
| sdio_i | input | 1 | Serial data from the pad |
| sdio_o | output | 1 | Serial data to the pad |
| sdio_oe | output | 1 | Pad output enable for serial data |
| wp_i | input | 1 | Write protect level |
| reg_addr_o | output | 5 | Register-file address |
| reg_wdata_o | output | 8 | Register-file write data |
| reg_we_o | output | 1 | Register-file write strobe, one cycle |
| reg_rdata_i | input | 8 | Register-file read data (combinational on address) |

## Verification
A wrong bit counter or a stale shift register shows up in three ways. The bit order of a returned byte rotates. A write strobe lands on the wrong address. A strobe fires a byte early or late. Each of these is visible at the register port within one byte time of the fault. A burst address that advances wrongly appears on the first byte after the increment, as an off-by-one register value. A phase flag that survives the fall of chip enable appears on the next transfer, as a strobe that should not happen or as the data line being driven during a command.

// File: rtl/serial3w_regport.sv
module serial3w_regport #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int BURST_LAST = 15,
  parameter int PROT_ADDR  = 7,
  parameter int SYNC_N     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  input  logic              wp_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);

  localparam int CMD_W = ADDR_W + 3;
  localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W = $clog2(MAXB);
  localparam logic [CNT_W-1:0]  CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0]  DAT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] BLAST    = ADDR_W'(BURST_LAST);
  localparam logic [ADDR_W-1:0] PADDR    = ADDR_W'(PROT_ADDR);
  localparam logic [ADDR_W-1:0] BCODE    = {ADDR_W{1'b1}};

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_HOLD} phase_t;

  logic [SYNC_N-1:0] ce_sy, ck_sy, di_sy;
  logic ck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sy <= '0;
      ck_sy <= '0;
      di_sy <= '0;
      ck_d  <= 1'b0;
    end else begin
      ce_sy <= {ce_sy[SYNC_N-2:0], ce_i};
      ck_sy <= {ck_sy[SYNC_N-2:0], sclk_i};
      di_sy <= {di_sy[SYNC_N-2:0], sdio_i};
      ck_d  <= ck_sy[SYNC_N-1];
    end
  end

  wire ce_s = ce_sy[SYNC_N-1];
  wire ck_s = ck_sy[SYNC_N-1];
  wire di_s = di_sy[SYNC_N-1];
  wire rise = ce_s &  ck_s & ~ck_d;
  wire fall = ce_s & ~ck_s &  ck_d;

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-2:0]  cmd_sh;
  logic [DATA_W-2:0] dat_sh;
  logic [DATA_W-2:0] tx;
  logic [ADDR_W-1:0] addr_q, waddr_q;
  logic [DATA_W-1:0] wdat_q;
  logic              burst_q, spent_q, drive_q, sdo_q, we_q;

  wire [CMD_W-1:0]  cmd_full = {di_s, cmd_sh};
  wire              cmd_ok   = cmd_full[CMD_W-1] & ~cmd_full[CMD_W-2];
  wire [ADDR_W-1:0] cmd_adr  = cmd_full[ADDR_W:1];
  wire              cmd_rd   = cmd_full[0];
  wire              is_burst = (cmd_adr == BCODE);
  wire              wr_allow = ~wp_i | (addr_q == PADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_CMD; cnt <= '0; cmd_sh <= '0; dat_sh <= '0; tx <= '0;
      addr_q <= '0; waddr_q <= '0; wdat_q <= '0;
      burst_q <= 1'b0; spent_q <= 1'b0; drive_q <= 1'b0; sdo_q <= 1'b0; we_q <= 1'b0;
    end else if (!ce_s) begin
      ph <= PH_CMD; cnt <= '0; cmd_sh <= '0; dat_sh <= '0; tx <= '0;
      addr_q <= '0; burst_q <= 1'b0; spent_q <= 1'b0; drive_q <= 1'b0;
      sdo_q <= 1'b0; we_q <= 1'b0;
    end else begin
      we_q <= 1'b0;
      case (ph)
        PH_CMD: if (rise) begin
          cmd_sh <= cmd_full[CMD_W-1:1];
          if (cnt == CMD_LAST) begin
            cnt <= '0;
            if (!cmd_ok) ph <= PH_HOLD;
            else begin
              burst_q <= is_burst;
              addr_q  <= is_burst ? '0 : cmd_adr;
              ph      <= cmd_rd ? PH_RD : PH_WR;
            end
          end else cnt <= cnt + 1'b1;
        end
        PH_WR: if (rise) begin
          dat_sh <= {di_s, dat_sh[DATA_W-2:1]};
          if (cnt == DAT_LAST) begin
            cnt     <= '0;
            we_q    <= wr_allow;
            waddr_q <= addr_q;
            wdat_q  <= {di_s, dat_sh};
            if (!burst_q || addr_q == BLAST) ph <= PH_HOLD;
            else addr_q <= addr_q + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        PH_RD: if (fall) begin
          if (spent_q) drive_q <= 1'b0;
          else begin
            drive_q <= 1'b1;
            if (cnt == '0) begin
              sdo_q <= reg_rdata_i[0];
              tx    <= reg_rdata_i[DATA_W-1:1];
            end else begin
              sdo_q <= tx[0];
              tx    <= tx >> 1;
            end
            if (cnt == DAT_LAST) begin
              cnt <= '0;
              if (burst_q) begin
                if (addr_q == BLAST) spent_q <= 1'b1;
                else addr_q <= addr_q + 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdat_q;
  assign reg_addr_o  = we_q ? waddr_q : addr_q;
  assign sdio_o      = sdo_q;
  assign sdio_oe     = ce_i & drive_q;

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  // R10
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (!$past(wp_i) || reg_addr_o == PADDR));

  // R8
  burst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && burst_q) |-> (reg_addr_o <= BLAST));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (!drive_q && !reg_we_o));

  // R3
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (ph == PH_RD));

  // R6
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_q) |-> $past(fall));

endmodule

// File: tb/tb_serial3w_regport.sv
module tb_serial3w_regport;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0, wp = 1'b0;
  logic sdo, oe, we;
  logic [4:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [32];
  int wr_cnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial3w_regport dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe(oe), .wp_i(wp), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata)
  );

  assign rdata = mem[addr];

  always @(posedge clk) if (we) begin
    mem[addr] <= wdata;
    wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic d);
    sdi = d; waitc(HALF); sclk = 1'b1; waitc(HALF); sclk = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 0; i < 8; i++) clk_bit(b[i]);
  endtask

  task automatic recv(output logic [7:0] b, output bit oe_ok);
    oe_ok = 1;
    for (int i = 0; i < 8; i++) begin
      waitc(HALF);
      b[i] = sdo;
      if (!oe) oe_ok = 0;
      sclk = 1'b1; waitc(HALF); sclk = 1'b0;
    end
  endtask

  task automatic open_x;  ce = 1'b1; waitc(4); endtask
  task automatic close_x; waitc(4); ce = 1'b0; waitc(8); endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] d);
    open_x; send({2'b10, a, 1'b0}); send(d); close_x;
  endtask

  task automatic do_read(input logic [4:0] a, output logic [7:0] d);
    bit ok;
    open_x; send({2'b10, a, 1'b1}); recv(d, ok); close_x;
  endtask

  task automatic t_reset;
    chk("R11 oe after reset", oe, 0);
    chk("R11 we after reset", we, 0);
  endtask

  task automatic t_single_write;
    int w0 = wr_cnt;
    open_x; send(8'h8A); send(8'hA6); send(8'h55); close_x;
    chk("R5 single write strobes", wr_cnt - w0, 1);
    chk("R2 R5 single write value lsb first", mem[5], 8'hA6);
  endtask

  task automatic t_single_read;
    logic [7:0] b; bit ok;
    mem[9] = 8'h3C;
    open_x; send(8'h93);
    recv(b, ok);
    chk("R6 single read value", b, 8'h3C);
    chk("R6 oe during read", ok, 1);
    recv(b, ok); chk("R7 repeat byte 1", b, 8'h3C);
    recv(b, ok); chk("R7 repeat byte 2", b, 8'h3C);
    ce = 1'b0; waitc(1);
    chk("R3 oe released with ce low", oe, 0);
    waitc(8);
  endtask

  task automatic t_burst_write;
    int w0 = wr_cnt; int bad = 0;
    mem[16] = 8'hEE;
    open_x; send(8'hBE);
    for (int i = 0; i < 17; i++) send(8'h40 + 8'(i));
    close_x;
    chk("R8 burst write strobes", wr_cnt - w0, 16);
    for (int i = 0; i < 16; i++) if (mem[i] != 8'h40 + 8'(i)) bad++;
    chk("R8 burst write contents", bad, 0);
    chk("R8 address 16 untouched", mem[16], 8'hEE);
  endtask

  task automatic t_burst_read;
    logic [7:0] b; bit ok; int bad = 0;
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 7 + 1);
    open_x; send(8'hBF);
    for (int i = 0; i < 16; i++) begin
      recv(b, ok);
      if (b != 8'(i * 7 + 1) || !ok) begin
        bad++;
        $display("FAIL R9 burst byte %0d: actual=%0h expected=%0h", i, b, 8'(i * 7 + 1));
      end
    end
    chk("R9 burst read bytes", bad, 0);
    waitc(HALF);
    chk("R9 line released after 16 bytes", oe, 0);
    close_x;
  endtask

  task automatic t_wp;
    logic [7:0] b; int w0;
    mem[3] = 8'h22;
    wp = 1'b1; w0 = wr_cnt;
    do_write(5'd3, 8'h11);
    chk("R10 protected write no strobe", wr_cnt - w0, 0);
    do_read(5'd3, b);
    chk("R10 protected register unchanged", b, 8'h22);
    do_write(5'd7, 8'h80);
    chk("R10 protect register writable", mem[7], 8'h80);
    wp = 1'b0;
  endtask

  task automatic t_abort;
    int w0 = wr_cnt;
    open_x;
    for (int i = 0; i < 4; i++) clk_bit(1'b1);
    ce = 1'b0; waitc(8);
    do_write(5'd2, 8'h5A);
    chk("R1 write after abort strobes", wr_cnt - w0, 1);
    chk("R1 write after abort value", mem[2], 8'h5A);
  endtask

  task automatic t_bad_cmd;
    logic [7:0] b; bit ok; int w0 = wr_cnt;
    open_x; send(8'hC4); send(8'h77); close_x;
    chk("R4 bit6 set no strobe", wr_cnt - w0, 0);
    open_x; send(8'h13); recv(b, ok); close_x;
    ok = 1;
    chk("R4 bit7 clear no strobe", wr_cnt - w0, 0);
  endtask

  task automatic t_bad_read_oe;
    logic [7:0] b; bit ok; bit any = 0;
    open_x; send(8'h13);
    for (int i = 0; i < 8; i++) begin
      waitc(HALF); if (oe) any = 1;
      sclk = 1'b1; waitc(HALF); sclk = 1'b0;
    end
    close_x;
    chk("R4 R3 invalid read never drives", any, 0);
    b = 0; ok = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    waitc(3); rst_n = 1'b1; waitc(4);
    t_reset;
    t_single_write;
    t_single_read;
    t_burst_write;
    t_burst_read;
    t_wp;
    t_abort;
    t_bad_cmd;
    t_bad_read_oe;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule